// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a direct-mapped cache with 32-byte lines and hides part of the 16-cycle refill cost of the level below. When the cache misses, it presents the missing block address on the lookup port before it goes further down. The stream buffer is a small FIFO of prefetched blocks. Only the oldest entry is compared against the lookup address. If that entry holds the block and its data is present, the block goes back to the cache in the same cycle and the FIFO advances. Any other outcome is reported as a miss. A miss empties the buffer and starts a new stream at the block after the missed one.

While a stream is running, the block keeps sending requests for consecutive block addresses to the next level until every FIFO slot is taken. Responses come back in request order. A response that belongs to a request sent before the last restart is dropped, so it never lands in the new stream. The lookup requester holds its request until it sees a response. This lets the block hold back its answer while the head entry has the right tag but its data is still on the way.

Top module: `stream_buffer`

## Requirements
- R1: After reset, the block sends no prefetch request and gives no lookup response until the first lookup miss has started a stream.
- R2: While `miss_req` is high, if the head entry is allocated, its tag equals `miss_blk` and its data has arrived, then in that same cycle `resp_valid`=1, `resp_hit`=1 and `resp_data` is the head block. The head is removed at the next clock edge.
- R3: While `miss_req` is high, if the buffer is empty or the head tag differs from `miss_blk`, then in that same cycle `resp_valid`=1 and `resp_hit`=0. Every entry is dropped at the next clock edge and a new stream starts at `miss_blk`+1.
- R4: Every accepted prefetch address is the previous accepted address plus one. The first address after a restart is the restart block.
- R5: A prefetch request is raised only while fewer than DEPTH entries (default 4) are allocated. Once all slots are taken, `pf_req_valid` is 0.
- R6: If the head tag matches but its data has not yet arrived, the block gives no response. It answers with a hit once the data is in.
- R7: Prefetch responses that belong to requests sent before a restart are discarded and never returned to the cache.
- R8: While `pf_req_valid`=1 and `pf_req_ready`=0, the request stays raised with an unchanged address unless a restart happens.
- R9: No more than 2*DEPTH prefetch requests, counting discarded ones, are outstanding at the next level at any time.
- R10: Only the head entry is compared. A lookup for a block held in a later entry is a miss and restarts the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_req | input | 1 | Cache miss lookup, held until `resp_valid` |
| miss_blk | input | BLK_W | Block address of the missed line |
| resp_valid | output | 1 | Lookup answered this cycle |
| resp_hit | output | 1 | 1 = block supplied from head entry, 0 = go to next level |
| resp_data | output | DATA_W | Block data on a hit |
| pf_req_valid | output | 1 | Prefetch request to next level |
| pf_req_addr | output | BLK_W | Block address being prefetched |
| pf_req_ready | input | 1 | Next level accepts the request |
| pf_rsp_valid | input | 1 | In-order prefetch data return |
| pf_rsp_data | input | DATA_W | Returned block |

## Verification
The hardest case to reach is a restart that happens while old requests are still in flight, so that stale and fresh responses arrive back to back. The bench lengthens the next-level latency and forces three misses a few cycles apart. The outstanding count then reaches its 2*DEPTH ceiling while the buffer is empty. The bench checks that issuing stops, and that the first hit after the restart returns the new stream's data and not a stale block. A second case that needs timing is a lookup landing on a head entry whose data is still pending. The bench issues it right after a restart and measures how long the answer takes.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {LK_IDLE, LK_HIT, LK_WAIT, LK_MISS} lk_kind_e;

  function automatic int wrap_inc(int p, int depth);
    return (p >= depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 27,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              pop,
  output logic              head_alloc,
  output logic              head_ready,
  output logic [TAG_W-1:0]  head_tag,
  output logic [DATA_W-1:0] head_data,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [PW-1:0] hd, tl, fp;
  logic [CW-1:0] cnt;
  logic [DEPTH-1:0] used, rdy;
  logic [TAG_W-1:0]  tags  [DEPTH];
  logic [DATA_W-1:0] datas [DEPTH];

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return PW'(sb_pkg::wrap_inc(int'(p), DEPTH));
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              used_q, rdy_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              is_hd, is_tl, is_fp;

    assign is_hd = (hd == PW'(i));
    assign is_tl = (tl == PW'(i));
    assign is_fp = (fp == PW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q <= 1'b0;
        rdy_q  <= 1'b0;
      end else if (flush || (pop && is_hd)) begin
        used_q <= 1'b0;
        rdy_q  <= 1'b0;
      end else begin
        if (alloc && is_tl) used_q <= 1'b1;
        if (fill && is_fp)  rdy_q  <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc && is_tl) tag_q  <= alloc_tag;
      if (fill && is_fp)  data_q <= fill_data;
    end

    assign used[i]  = used_q;
    assign rdy[i]   = rdy_q;
    assign tags[i]  = tag_q;
    assign datas[i] = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd  <= '0;
      tl  <= '0;
      fp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      hd  <= '0;
      tl  <= '0;
      fp  <= '0;
      cnt <= '0;
    end else begin
      if (pop)   hd <= step(hd);
      if (alloc) tl <= step(tl);
      if (fill)  fp <= step(fp);
      cnt <= cnt + CW'(alloc) - CW'(pop);
    end
  end

  assign head_alloc = used[hd];
  assign head_ready = rdy[hd];
  assign head_tag   = tags[hd];
  assign head_data  = datas[hd];
  assign occ        = cnt;
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup #(
  parameter int TAG_W = 27
) (
  input  logic             miss_req,
  input  logic [TAG_W-1:0] miss_blk,
  input  logic             head_alloc,
  input  logic             head_ready,
  input  logic [TAG_W-1:0] head_tag,
  output sb_pkg::lk_kind_e kind
);
  always_comb begin
    kind = sb_pkg::LK_IDLE;
    if (miss_req) begin
      if (!head_alloc || head_tag != miss_blk) kind = sb_pkg::LK_MISS;
      else if (head_ready)                     kind = sb_pkg::LK_HIT;
      else                                     kind = sb_pkg::LK_WAIT;
    end
  end
endmodule

// File: rtl/sb_issuer.sv
module sb_issuer #(
  parameter int TAG_W    = 27,
  parameter int PEND_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [TAG_W-1:0] restart_blk,
  input  logic             room,
  input  logic             pf_ready,
  input  logic             rsp_valid,
  output logic             pf_valid,
  output logic [TAG_W-1:0] pf_addr,
  output logic             fire,
  output logic             rsp_keep,
  output logic [$clog2(PEND_MAX+1)-1:0] pending
);
  localparam int PDW = $clog2(PEND_MAX+1);

  logic             active;
  logic [TAG_W-1:0] nxt;
  logic [PDW-1:0]   pend, stale, pend_n;

  function automatic logic [TAG_W-1:0] next_blk(logic [TAG_W-1:0] a);
    return a + TAG_W'(1);
  endfunction

  assign pf_valid = active && room && !flush && (pend < PDW'(PEND_MAX));
  assign pf_addr  = nxt;
  assign fire     = pf_valid && pf_ready;
  assign rsp_keep = rsp_valid && (stale == '0) && !flush;
  assign pend_n   = pend + PDW'(fire) - PDW'(rsp_valid);
  assign pending  = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      nxt    <= '0;
      pend   <= '0;
      stale  <= '0;
    end else begin
      pend <= pend_n;
      if (flush) begin
        active <= 1'b1;
        nxt    <= next_blk(restart_blk);
        stale  <= pend_n;
      end else begin
        if (fire) nxt <= next_blk(nxt);
        if (rsp_valid && stale != '0) stale <= stale - PDW'(1);
      end
    end
  end
endmodule

// File: rtl/stream_buffer.sv
module stream_buffer #(
  parameter int BLK_W  = 27,
  parameter int DATA_W = 256,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [BLK_W-1:0]  miss_blk,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              pf_req_valid,
  output logic [BLK_W-1:0]  pf_req_addr,
  input  logic              pf_req_ready,
  input  logic              pf_rsp_valid,
  input  logic [DATA_W-1:0] pf_rsp_data
);
  localparam int CW       = $clog2(DEPTH+1);
  localparam int PEND_MAX = 2 * DEPTH;
  localparam int PDW      = $clog2(PEND_MAX+1);

  sb_pkg::lk_kind_e kind;
  logic              head_alloc, head_ready;
  logic [BLK_W-1:0]  head_tag;
  logic [DATA_W-1:0] head_data;
  logic [CW-1:0]     occ;
  logic [PDW-1:0]    pending;
  logic              hit_evt, flush_evt, pf_fire, rsp_keep, room;

  assign hit_evt   = (kind == sb_pkg::LK_HIT);
  assign flush_evt = (kind == sb_pkg::LK_MISS);
  assign room      = (occ < CW'(DEPTH));

  sb_lookup #(.TAG_W(BLK_W)) u_lookup (
    .miss_req   (miss_req),
    .miss_blk   (miss_blk),
    .head_alloc (head_alloc),
    .head_ready (head_ready),
    .head_tag   (head_tag),
    .kind       (kind)
  );

  sb_fifo #(.DEPTH(DEPTH), .TAG_W(BLK_W), .DATA_W(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_evt),
    .alloc      (pf_fire),
    .alloc_tag  (pf_req_addr),
    .fill       (rsp_keep),
    .fill_data  (pf_rsp_data),
    .pop        (hit_evt),
    .head_alloc (head_alloc),
    .head_ready (head_ready),
    .head_tag   (head_tag),
    .head_data  (head_data),
    .occ        (occ)
  );

  sb_issuer #(.TAG_W(BLK_W), .PEND_MAX(PEND_MAX)) u_issuer (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush_evt),
    .restart_blk (miss_blk),
    .room        (room),
    .pf_ready    (pf_req_ready),
    .rsp_valid   (pf_rsp_valid),
    .pf_valid    (pf_req_valid),
    .pf_addr     (pf_req_addr),
    .fire        (pf_fire),
    .rsp_keep    (rsp_keep),
    .pending     (pending)
  );

  assign resp_valid = hit_evt || flush_evt;
  assign resp_hit   = hit_evt;
  assign resp_data  = hit_evt ? head_data : '0;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int BLK_W = 27,
  parameter int DEPTH = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           miss_req,
  input logic [BLK_W-1:0]               miss_blk,
  input logic                           resp_valid,
  input logic                           pf_req_valid,
  input logic [BLK_W-1:0]               pf_req_addr,
  input logic                           pf_req_ready,
  input logic                           hit_evt,
  input logic                           flush_evt,
  input logic [$clog2(DEPTH+1)-1:0]     occ,
  input logic [$clog2(2*DEPTH+1)-1:0]   pending
);
  logic             armed;
  logic [BLK_W-1:0] exp_n;
  logic             fire;

  assign fire = pf_req_valid && pf_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      exp_n <= '0;
    end else if (flush_evt) begin
      armed <= 1'b1;
      exp_n <= miss_blk + BLK_W'(1);
    end else if (fire) begin
      exp_n <= pf_req_addr + BLK_W'(1);
    end
  end

  // R1
  idle_until_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !pf_req_valid);

  // R2
  head_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> int'(occ) == int'($past(occ)) - 1 + int'($past(fire)));

  // R3
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> occ == '0);

  // R3
  resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> miss_req);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && armed |-> pf_req_addr == exp_n);

  // R5
  full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) >= DEPTH |-> !pf_req_valid);

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid && !pf_req_ready |=> flush_evt || (pf_req_valid && $stable(pf_req_addr)));

  // R9
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pending) <= 2 * DEPTH);
endmodule

bind stream_buffer sb_checker #(.BLK_W(BLK_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_req     (miss_req),
  .miss_blk     (miss_blk),
  .resp_valid   (resp_valid),
  .pf_req_valid (pf_req_valid),
  .pf_req_addr  (pf_req_addr),
  .pf_req_ready (pf_req_ready),
  .hit_evt      (hit_evt),
  .flush_evt    (flush_evt),
  .occ          (occ),
  .pending      (pending)
);

// File: tb/stream_buffer_test.sv
module stream_buffer_test;
  localparam int BW = 27;
  localparam int DW = 256;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic miss_req = 0;
  logic [BW-1:0] miss_blk = '0;
  logic resp_valid, resp_hit;
  logic [DW-1:0] resp_data;
  logic pf_req_valid;
  logic [BW-1:0] pf_req_addr;
  logic pf_req_ready = 1;
  logic pf_rsp_valid = 0;
  logic [DW-1:0] pf_rsp_data = '0;

  stream_buffer #(.BLK_W(BW), .DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_blk(miss_blk),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr), .pf_req_ready(pf_req_ready),
    .pf_rsp_valid(pf_rsp_valid), .pf_rsp_data(pf_rsp_data));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int lat = 16;
  bit taken = 0;
  bit pf_on = 0;
  logic [BW-1:0] exp_pf = '0;

  typedef struct { bit hit; logic [BW-1:0] a; } exp_t;
  exp_t sb_q[$];
  logic [BW-1:0] nl_addr[$];
  int nl_due[$];

  function automatic logic [DW-1:0] pat(logic [BW-1:0] a);
    logic [31:0] w;
    w = {5'h0B, a} ^ 32'h5A3C_0000;
    return {8{w}} ^ {{(DW-32){1'b0}}, ~w};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) cyc++;

  // next level of memory: in-order responses after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (nl_addr.size() > 0 && nl_due[0] <= cyc) begin
        pf_rsp_valid = 1;
        pf_rsp_data  = pat(nl_addr[0]);
        void'(nl_addr.pop_front());
        void'(nl_due.pop_front());
      end else begin
        pf_rsp_valid = 0;
      end
      #2;
      if (rst_n && pf_req_valid && pf_req_ready) begin
        // R4: consecutive block addresses
        if (pf_on) chk(pf_req_addr == exp_pf, "R4", "prefetch addr", 64'(pf_req_addr), 64'(exp_pf));
        exp_pf = pf_req_addr + 1;
        nl_addr.push_back(pf_req_addr);
        nl_due.push_back(cyc + lat);
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && miss_req && resp_valid && !taken) begin
        exp_t e;
        taken = 1;
        if (sb_q.size() == 0) begin
          chk(0, "R2", "unexpected response", 64'(miss_blk), 0);
        end else begin
          e = sb_q.pop_front();
          if (e.hit) begin
            chk(resp_hit == 1'b1, "R2", "hit flag", 64'(resp_hit), 1);
            chk(resp_data == pat(e.a), "R2", "hit data", resp_data[63:0], pat(e.a)[63:0]);
          end else begin
            chk(resp_hit == 1'b0, "R3", "miss flag", 64'(resp_hit), 0);
            exp_pf = e.a + 1;
            pf_on = 1;
          end
        end
      end
    end
  end

  task automatic lookup(logic [BW-1:0] a, bit hit);
    exp_t e;
    e.hit = hit;
    e.a = a;
    sb_q.push_back(e);
    @(negedge clk);
    miss_req = 1;
    miss_blk = a;
    do @(posedge clk); while (!taken);
    @(negedge clk);
    miss_req = 0;
    taken = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) begin
      @(negedge clk); #2;
      // R1: no activity before first miss
      chk(!pf_req_valid && !resp_valid, "R1", "idle after reset", 64'({pf_req_valid, resp_valid}), 0);
    end

    // R3: empty buffer misses, starts stream at 101
    lookup(100, 0);
    idle(40);
    @(negedge clk); #2;
    // R5: four slots taken, no more requests
    chk(!pf_req_valid, "R5", "stop when full", 64'(pf_req_valid), 0);
    for (int i = 101; i <= 108; i++) lookup(BW'(i), 1);   // R2 hits in order

    // R6: head tag matches while data still pending
    idle(40);
    lookup(200, 0);
    t0 = cyc;
    lookup(201, 1);
    chk((cyc - t0) >= 12, "R6", "waited for data", 64'(cyc - t0), 12);

    // R10: block in a later entry is a miss
    idle(40);
    lookup(203, 0);
    idle(40);
    lookup(204, 1);

    // R7: restart while requests are in flight
    lookup(300, 0);
    idle(3);
    lookup(400, 0);
    idle(40);
    lookup(401, 1);
    lookup(402, 1);

    // R8: backpressure holds request stable
    idle(40);
    pf_req_ready = 0;
    lookup(500, 0);
    repeat (5) begin
      @(negedge clk); #2;
      chk(pf_req_valid && pf_req_addr == 501, "R8", "held request", 64'(pf_req_addr), 501);
    end
    pf_req_ready = 1;
    idle(40);
    lookup(501, 1);

    // R9: outstanding ceiling with stale requests
    idle(40);
    lat = 40;
    lookup(600, 0);
    idle(6);
    lookup(700, 0);
    idle(6);
    lookup(800, 0);
    idle(2);
    @(negedge clk); #2;
    chk(!pf_req_valid, "R9", "issue stops at ceiling", 64'(pf_req_valid), 0);
    idle(150);
    lookup(801, 1);   // R7: stale data never returned
    lookup(802, 1);

    idle(5);
    chk(sb_q.size() == 0, "R2", "scoreboard drained", 64'(sb_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule